// File: doc/BRIEF.md
# Status Byte Keeper and Write Permission Guard

This block sits beside the command engine of a serial nonvolatile memory and owns the one-byte status word. The status word holds a protect-enable flag, a two-bit block-protect code, the write-enable latch and a busy indication. The engine reports completed operations as single-cycle strobes when chip select rises. These are write-enable, write-disable, status-write (with its data byte) and array-write-done, and each comes with the bit count of the finished frame. The block updates the status word from these strobes and reports back, every cycle, whether an array write to the presented address is allowed and whether a status write is allowed.

The persistent fields (protect-enable and block-protect) are plain registers. They reset to a parameterised value and change only through a permitted status write. All inputs are plain control and status pins. Strobes are one cycle long and always accepted, so there is no valid/ready handshake and no back-pressure. The engine samples the two permit outputs in the cycle it raises a strobe.

Top module: `nvm_status_guard`

## Requirements
- R1: During and right after reset the status byte equals {INIT_CFG[2], 3'b000, INIT_CFG[1:0], 1'b0, busy_in}, and both permits are 0.
- R2: Status bits 6..4 always read 0. Bit 0 equals busy_in in the same cycle. Bit 1 is the write-enable latch, bits 3..2 the block-protect code and bit 7 protect-enable.
- R3: A write-enable strobe with frame_len == 8 sets the latch on the next edge, and a write-disable strobe with frame_len == 8 clears it. Either strobe with any other frame_len leaves the latch unchanged.
- R4: A status write that is committed, or an array-write-done strobe, clears the latch on the next edge.
- R5: When write-enable (length 8) and write-done strobe in the same cycle, the latch ends set. When write-enable and write-disable (both length 8) coincide, it ends clear.
- R6: A committed status write copies data bits 7, 3 and 2 into bits 7, 3 and 2 of the status byte and ignores the other data bits.
- R7: status_wr_ok = latch AND (NOT protect-enable OR wp_in). A status write strobed while status_wr_ok is 0 changes neither the status byte nor the latch. wp_in matters only in the strobe cycle.
- R8: array_wr_ok is 0 whenever the latch is 0.
- R9: The block-protect code selects the protected range: 00 none, 01 addresses 0x300..0x3FF, 10 addresses 0x200..0x3FF, 11 all. array_wr_ok = latch AND address not protected.
- R10: array_wr_ok does not depend on wp_in or on protect-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wren_stb | input | 1 | Write-enable frame finished |
| wrdi_stb | input | 1 | Write-disable frame finished |
| wrsr_stb | input | 1 | Status-write frame finished |
| wrsr_data | input | 8 | Data byte of the status-write frame |
| wr_done_stb | input | 1 | Array write completed successfully |
| frame_len | input | FRAME_W | Bit count of the finished frame |
| wp_in | input | 1 | Write-protect pin level (0 asserts protection) |
| busy_in | input | 1 | Internal write in progress |
| tgt_addr | input | ADDR_W | Array address of the pending write |
| status_q | output | 8 | Status byte for readback |
| array_wr_ok | output | 1 | Array write to tgt_addr permitted |
| status_wr_ok | output | 1 | Status write permitted |

## Verification
Two pairs of functions can land on the same edge. The latch can be set by a write-enable frame while a finishing array write clears it. A status-write commit can coincide with the write-protect pin changing. The bench raises write-enable and write-done in one cycle and expects the latch set. It then raises write-enable and write-disable together and expects it clear. It also commits a status write with wp_in high, drops wp_in on the very next cycle, and expects the committed value to hold.

// File: rtl/nvm_status_pkg.sv
package nvm_status_pkg;
  localparam int SB_WPEN = 7;
  localparam int SB_BP_HI = 3;
  localparam int SB_BP_LO = 2;
  localparam int SB_WEL = 1;
  localparam int SB_WIP = 0;

  typedef struct packed {
    logic       wpen;
    logic [1:0] bp;
  } nv_cfg_t;

  function automatic logic [7:0] pack_status(nv_cfg_t c, logic wel, logic wip);
    return {c.wpen, 3'b000, c.bp, wel, wip};
  endfunction
endpackage

// File: rtl/nvm_wel_ctrl.sv
module nvm_wel_ctrl #(
  parameter int FRAME_W = 6,
  parameter int OP_BITS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wren_stb,
  input  logic               wrdi_stb,
  input  logic [FRAME_W-1:0] frame_len,
  input  logic               wrsr_commit,
  input  logic               wr_done_stb,
  output logic               wel
);
  logic len_ok;
  assign len_ok = (frame_len == FRAME_W'(OP_BITS));

  // disable beats enable; enable beats the clear from a finished write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wel <= 1'b0;
    else if (wrdi_stb && len_ok) wel <= 1'b0;
    else if (wren_stb && len_ok) wel <= 1'b1;
    else if (wrsr_commit || wr_done_stb) wel <= 1'b0;
  end
endmodule

// File: rtl/nvm_cfg_store.sv
module nvm_cfg_store
  import nvm_status_pkg::*;
#(
  parameter logic [2:0] INIT_CFG = 3'b000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       commit,
  input  logic [7:0] data,
  output nv_cfg_t    cfg
);
  logic unused_bits;
  assign unused_bits = ^{data[6:4], data[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg <= nv_cfg_t'(INIT_CFG);
    else if (commit) begin
      cfg.wpen <= data[SB_WPEN];
      cfg.bp   <= data[SB_BP_HI:SB_BP_LO];
    end
  end
endmodule

// File: rtl/nvm_block_guard.sv
module nvm_block_guard #(
  parameter int ADDR_W = 10
) (
  input  logic [1:0]        bp,
  input  logic [ADDR_W-1:0] addr,
  output logic              prot
);
  localparam logic [ADDR_W-1:0] QTR_BASE  = {2'b11, {(ADDR_W-2){1'b0}}};
  localparam logic [ADDR_W-1:0] HALF_BASE = {2'b10, {(ADDR_W-2){1'b0}}};

  always_comb begin
    unique case (bp)
      2'b00:   prot = 1'b0;
      2'b01:   prot = (addr >= QTR_BASE);
      2'b10:   prot = (addr >= HALF_BASE);
      default: prot = 1'b1;
    endcase
  end
endmodule

// File: rtl/nvm_status_guard.sv
module nvm_status_guard
  import nvm_status_pkg::*;
#(
  parameter int         ADDR_W   = 10,
  parameter int         FRAME_W  = 6,
  parameter int         OP_BITS  = 8,
  parameter logic [2:0] INIT_CFG = 3'b000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wren_stb,
  input  logic               wrdi_stb,
  input  logic               wrsr_stb,
  input  logic [7:0]         wrsr_data,
  input  logic               wr_done_stb,
  input  logic [FRAME_W-1:0] frame_len,
  input  logic               wp_in,
  input  logic               busy_in,
  input  logic [ADDR_W-1:0]  tgt_addr,
  output logic [7:0]         status_q,
  output logic               array_wr_ok,
  output logic               status_wr_ok
);
  logic    wel;
  logic    prot;
  logic    wrsr_commit;
  nv_cfg_t cfg;

  assign status_wr_ok = wel & (~cfg.wpen | wp_in);
  assign wrsr_commit  = wrsr_stb & status_wr_ok;
  assign array_wr_ok  = wel & ~prot;
  assign status_q     = pack_status(cfg, wel, busy_in);

  nvm_wel_ctrl #(.FRAME_W(FRAME_W), .OP_BITS(OP_BITS)) u_wel (
    .clk(clk), .rst_n(rst_n), .wren_stb(wren_stb), .wrdi_stb(wrdi_stb),
    .frame_len(frame_len), .wrsr_commit(wrsr_commit),
    .wr_done_stb(wr_done_stb), .wel(wel)
  );

  nvm_cfg_store #(.INIT_CFG(INIT_CFG)) u_cfg (
    .clk(clk), .rst_n(rst_n), .commit(wrsr_commit), .data(wrsr_data), .cfg(cfg)
  );

  nvm_block_guard #(.ADDR_W(ADDR_W)) u_blk (
    .bp(cfg.bp), .addr(tgt_addr), .prot(prot)
  );
endmodule

// File: rtl/nvm_status_chk.sv
module nvm_status_chk #(
  parameter int FRAME_W = 6,
  parameter int OP_BITS = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wren_stb,
  input logic               wrdi_stb,
  input logic               wrsr_stb,
  input logic               wr_done_stb,
  input logic [FRAME_W-1:0] frame_len,
  input logic               busy_in,
  input logic [7:0]         status_q,
  input logic               array_wr_ok,
  input logic               status_wr_ok
);
  logic len8;
  assign len8 = (frame_len == FRAME_W'(OP_BITS));

  p_fixed_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[6:4] == 3'b000 && status_q[0] == busy_in);

  p_wel_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wren_stb && len8 && !(wrdi_stb) |=> status_q[1]);

  p_wel_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wren_stb && len8) && !(wrdi_stb && len8) && !wrsr_stb && !wr_done_stb
    |=> $stable(status_q[1]));

  p_wrsr_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wrsr_stb && status_wr_ok && !(wren_stb && len8) |=> !status_q[1]);

  p_done_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done_stb && !(wren_stb && len8) |=> !status_q[1]);

  p_blocked_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wrsr_stb && !status_wr_ok |=> $stable(status_q[7:2]));

  p_array_needs_wel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !status_q[1] |-> !array_wr_ok);

  p_full_protect_r9: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[3:2] == 2'b11 |-> !array_wr_ok);
endmodule

bind nvm_status_guard nvm_status_chk #(.FRAME_W(FRAME_W), .OP_BITS(OP_BITS)) u_chk (.*);

// File: tb/sim_nvm_status_guard.sv
module sim_nvm_status_guard;
  localparam int ADDR_W  = 10;
  localparam int FRAME_W = 6;
  localparam int NVEC    = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wren_stb = 0, wrdi_stb = 0, wrsr_stb = 0, wr_done_stb = 0;
  logic [7:0] wrsr_data = '0;
  logic [FRAME_W-1:0] frame_len = '0;
  logic wp_in = 1'b1, busy_in = 1'b0;
  logic [ADDR_W-1:0] tgt_addr = '0;
  logic [7:0] status_q;
  logic array_wr_ok, status_wr_ok;
  int errs = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  nvm_status_guard #(.ADDR_W(ADDR_W), .FRAME_W(FRAME_W)) u0 (.*);

  // {wel, wpen, wp, bp[1:0], addr[9:0], exp_array_ok, exp_status_ok}
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 1'b1, 2'b00, 10'h000, 1'b0, 1'b0},
    {1'b1, 1'b0, 1'b0, 2'b00, 10'h000, 1'b1, 1'b1},
    {1'b1, 1'b1, 1'b0, 2'b00, 10'h1FF, 1'b1, 1'b0},
    {1'b1, 1'b1, 1'b1, 2'b00, 10'h3FF, 1'b1, 1'b1},
    {1'b1, 1'b0, 1'b1, 2'b01, 10'h2FF, 1'b1, 1'b1},
    {1'b1, 1'b0, 1'b1, 2'b01, 10'h300, 1'b0, 1'b1},
    {1'b1, 1'b1, 1'b0, 2'b10, 10'h1FF, 1'b1, 1'b0},
    {1'b1, 1'b1, 1'b0, 2'b10, 10'h200, 1'b0, 1'b0},
    {1'b1, 1'b0, 1'b0, 2'b11, 10'h000, 1'b0, 1'b1},
    {1'b1, 1'b1, 1'b1, 2'b11, 10'h3FF, 1'b0, 1'b1},
    {1'b0, 1'b1, 1'b0, 2'b01, 10'h000, 1'b0, 1'b0},
    {1'b1, 1'b0, 1'b0, 2'b10, 10'h3FF, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic en, input logic dis, input logic sr, input logic dn,
                        input logic [7:0] d, input int len);
    @(negedge clk);
    wren_stb = en; wrdi_stb = dis; wrsr_stb = sr; wr_done_stb = dn;
    wrsr_data = d; frame_len = FRAME_W'(len);
    @(negedge clk);
    wren_stb = 0; wrdi_stb = 0; wrsr_stb = 0; wr_done_stb = 0;
    wrsr_data = '0; frame_len = '0;
  endtask

  task automatic do_wren();         strobe(1, 0, 0, 0, 8'h00, 8);  endtask
  task automatic do_wrdi();         strobe(0, 1, 0, 0, 8'h00, 8);  endtask
  task automatic do_wrsr(input logic [7:0] d); strobe(0, 0, 1, 0, d, 16); endtask

  task automatic set_state(input logic wel, input logic wpen, input logic [1:0] bp);
    wp_in = 1'b1;
    do_wren();
    do_wrsr({wpen, 3'b000, bp, 2'b00});
    if (wel) do_wren();
    else do_wrdi();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 status in reset", status_q, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status after reset", status_q, 8'h00);
    chk("R1 array permit", array_wr_ok, 0);
    chk("R1 status permit", status_wr_ok, 0);

    // R7 R9 R10 R8: protection matrix walk
    for (int i = 0; i < NVEC; i++) begin
      logic [16:0] v;
      v = VEC[i];
      set_state(v[16], v[15], v[13:12]);
      wp_in = v[14];
      tgt_addr = v[11:2];
      #1;
      chk($sformatf("R9 R10 array permit vec %0d", i), array_wr_ok, v[1]);
      chk($sformatf("R7 status permit vec %0d", i), status_wr_ok, v[0]);
      chk($sformatf("R2 status byte vec %0d", i), status_q,
          {v[15], 3'b000, v[13:12], v[16], 1'b0});
    end

    // back to a clean state
    set_state(0, 0, 2'b00);
    wp_in = 1'b1;

    // R3: frame length qualifies enable/disable
    strobe(1, 0, 0, 0, 8'h00, 9);
    chk("R3 enable with 9 bits ignored", status_q[1], 0);
    do_wren();
    chk("R3 enable with 8 bits", status_q[1], 1);
    strobe(0, 1, 0, 0, 8'h00, 7);
    chk("R3 disable with 7 bits ignored", status_q[1], 1);
    do_wrdi();
    chk("R3 disable with 8 bits", status_q[1], 0);

    // R6: only bits 7,3,2 written; R4: commit clears latch
    do_wren();
    do_wrsr(8'hFF);
    chk("R6 R4 status after write of FF", status_q, 8'h8C);

    // R7: blocked while protect-enable set and wp low
    do_wren();
    wp_in = 1'b0;
    do_wrsr(8'h00);
    chk("R7 blocked write leaves status", status_q, 8'h8E);
    wp_in = 1'b1;
    do_wrsr(8'h00);
    chk("R7 write with wp high", status_q, 8'h00);

    // R7: wp dropping right after commit has no effect
    do_wren();
    do_wrsr(8'h84);
    wp_in = 1'b0;
    @(negedge clk);
    chk("R7 committed value kept", status_q, 8'h84);
    wp_in = 1'b1;

    // R2: busy mirrored on bit 0
    busy_in = 1'b1;
    #1;
    chk("R2 busy shows on bit 0", status_q[0], 1);
    busy_in = 1'b0;
    #1;
    chk("R2 busy cleared on bit 0", status_q[0], 0);

    // R4: write done clears latch
    do_wren();
    strobe(0, 0, 0, 1, 8'h00, 0);
    chk("R4 write done clears latch", status_q[1], 0);

    // R5: same-cycle collisions
    strobe(1, 0, 0, 1, 8'h00, 8);
    chk("R5 enable beats write done", status_q[1], 1);
    strobe(1, 1, 0, 0, 8'h00, 8);
    chk("R5 disable beats enable", status_q[1], 0);

    // R8: latch clear blocks array even with bp none
    set_state(0, 0, 2'b00);
    tgt_addr = 10'h010;
    #1;
    chk("R8 no latch no array write", array_wr_ok, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule